// File: doc/BRIEF.md
# Dual-Phase Blink Output Controller

This block holds two complete sets of output patterns and steers a bank of seventeen open-drain-style general-purpose outputs from one of them. Sixteen outputs draw their levels from pattern registers organised as byte-wide banks, one group of banks per phase. The seventeenth output is set by two bits of a configuration register, one bit per phase. The outputs are release enables: a stored 1 lets the pin float, so an external pull-up takes it high, and a stored 0 pulls the pin low.

Switching between the two pattern sets is gated by a blink enable flag. While that flag is set, the active phase is the exclusive-OR of a software flip flag and an external blink pin. Software, the pin, or both can therefore alternate the patterns. While the flag is clear, only the phase-0 set drives the outputs. The blink pin passes through a two-stage synchroniser. Its synchronised level can always be read back as a status bit, so the pin can also serve as a general-purpose input.

Registers are written through a simple synchronous write port and read through a combinational read port. Outputs are computed combinationally from the stored registers and the synchronised pin, so a register write is visible after the edge that stores it.

Top module: `blink_pattern_ctrl`

## Requirements
- R1: After reset every output is released (all ones), both phases' pattern registers read 0xFF, and the configuration register reads 0x0C with enable and flip clear (the status bit shows the synchronised pin).
- R2: While the enable flag (config bit 0) is 0, the outputs follow the phase-0 pattern and the phase-0 output-16 bit, whatever the flip flag and the blink pin do.
- R3: While the enable flag is 1, the active phase is flip flag (config bit 1) XOR the synchronised blink pin. Phase 1 selects the phase-1 patterns and the phase-1 output-16 bit; phase 0 selects the phase-0 ones.
- R4: The output polarity follows the stored bit: a 1 in the active pattern gives out_rel high (pin released), and a 0 gives out_rel low (pin driven low).
- R5: Output 16 is driven by config bit 2 in phase 0 and by config bit 3 in phase 1.
- R6: Reading a pattern register returns the value stored there, whichever phase is active and whatever the outputs show.
- R7: Config bit 7 is read-only and shows the synchronised blink pin level whether blink is enabled or not. Writes to bit 7 have no effect, and bits 4 to 6 read as 0.
- R8: A change on blink_pin reaches the status bit and the outputs exactly two clock edges later, and not after one.
- R9: Register map: address 0 holds the phase-0 bank for outputs 0-7, 1 the phase-0 bank for outputs 8-15, 2 and 3 the same banks for phase 1, and 4 the configuration. Addresses 5 to 7 read 0, and writes to them change nothing.
- R10: A write takes effect at the clock edge where wr_en is sampled high. Outputs and read data reflect it with no further delay, and no register changes while wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blink_pin | input | 1 | Asynchronous external phase pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational register read data |
| out_rel | output | 17 | Output release enables, 1 = released, 0 = driven low |

## Verification
The bench builds the block with its defaults: two 8-bit banks per phase and a two-stage synchroniser. At these values all seventeen outputs, the full address map and the three unmapped addresses can be reached, and each one is checked. The reference model crosses the enable flag with all four flip-and-pin combinations. The sample taken one edge after a pin change pins down the exact synchroniser latency. Writes to the status bit and to the unmapped addresses are checked through the read port and the outputs immediately after they happen.

// File: rtl/blink_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-phase blink output controller.
// Assumes the register data width is at least 8 bits, so the status bit fits.
package blink_pkg;
    // Configuration bit positions.
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_FLIP_BIT   = 1;
    localparam int CFG_O16P0_BIT  = 2;
    localparam int CFG_O16P1_BIT  = 3;
    localparam int CFG_STATUS_BIT = 7;

    // Writable configuration state.
    typedef struct packed {
        logic o16_p1;
        logic o16_p0;
        logic flip;
        logic en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{o16_p1: 1'b1, o16_p0: 1'b1, flip: 1'b0, en: 1'b0};
endpackage

// File: rtl/blink_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the asynchronous blink pin.
// Assumes pin_in may change at any time; lvl_out is its level delayed by STAGES edges.
module blink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic lvl_out
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the synchroniser flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_in};
    end

    assign lvl_out = chain[STAGES-1];

    // Cycles since reset, saturating, used to gate the latency check.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R8: output equals the pin as sampled two edges ago
            p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (age == 2'd2) |-> (lvl_out == $past(pin_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/pattern_regs.sv
`timescale 1ns/1ps
// Register file: pattern banks for both phases plus the configuration register.
// Assumes BANK_W >= 8. Banks are numbered from the lowest outputs upward.
// Map: phase-0 banks at 0..BANKS-1, phase-1 banks next, configuration last.
module pattern_regs
    import blink_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int BANKS  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BANK_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    blink_lvl,
    output logic [BANK_W-1:0]       rd_data,
    output logic [BANKS*BANK_W-1:0] pat0,
    output logic [BANKS*BANK_W-1:0] pat1,
    output cfg_t                    cfg
);
    localparam int CFG_ADDR = 2 * BANKS;

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            localparam int A0 = b;
            localparam int A1 = BANKS + b;

            // Phase-0 bank b: load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pat0[b*BANK_W +: BANK_W] <= '1;
                else if (wr_en && (int'(wr_addr) == A0))
                    pat0[b*BANK_W +: BANK_W] <= wr_data;
            end

            // Phase-1 bank b: load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pat1[b*BANK_W +: BANK_W] <= '1;
                else if (wr_en && (int'(wr_addr) == A1))
                    pat1[b*BANK_W +: BANK_W] <= wr_data;
            end
        end
    endgenerate

    // Configuration register: only the writable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RESET;
        else if (wr_en && (int'(wr_addr) == CFG_ADDR))
            cfg <= '{o16_p1: wr_data[CFG_O16P1_BIT], o16_p0: wr_data[CFG_O16P0_BIT],
                     flip: wr_data[CFG_FLIP_BIT], en: wr_data[CFG_EN_BIT]};
    end

    // Read mux: stored banks, configuration with live status, zero elsewhere.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (int'(rd_addr) == b)         rd_data = pat0[b*BANK_W +: BANK_W];
            if (int'(rd_addr) == BANKS + b) rd_data = pat1[b*BANK_W +: BANK_W];
        end
        if (int'(rd_addr) == CFG_ADDR) begin
            rd_data[CFG_EN_BIT]     = cfg.en;
            rd_data[CFG_FLIP_BIT]   = cfg.flip;
            rd_data[CFG_O16P0_BIT]  = cfg.o16_p0;
            rd_data[CFG_O16P1_BIT]  = cfg.o16_p1;
            rd_data[CFG_STATUS_BIT] = blink_lvl;
        end
    end

    // R10: storage holds whenever no write is presented
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pat0) && $stable(pat1) && $stable(cfg)));
endmodule

// File: rtl/phase_select.sv
`timescale 1ns/1ps
// Combinational selection of the active pattern set.
// Assumes blink_lvl is already synchronised; output 16 sits above the banked outputs.
module phase_select
    import blink_pkg::*;
#(
    parameter int NBANKED = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBANKED-1:0] pat0,
    input  logic [NBANKED-1:0] pat1,
    input  cfg_t               cfg,
    input  logic               blink_lvl,
    output logic [NBANKED:0]   out_rel
);
    logic use_p1;

    // Phase choice: flip XOR pin, gated by the enable flag.
    always_comb begin
        use_p1 = cfg.en & (cfg.flip ^ blink_lvl);
    end

    // Output mux: a 1 releases the pin, a 0 drives it low.
    always_comb begin
        out_rel = use_p1 ? {cfg.o16_p1, pat1} : {cfg.o16_p0, pat0};
    end

    // R2: with blink off, the flip flag and the pin cannot move the outputs
    p_off_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && $stable(cfg) && $stable(pat0)) |-> $stable(out_rel));

    // R3: enabled with an all-low phase-1 set active drives every pin low
    p_phase1_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && (cfg.flip != blink_lvl) && (pat1 == '0) && !cfg.o16_p1)
        |-> (out_rel == '0));
endmodule

// File: rtl/blink_pattern_ctrl.sv
`timescale 1ns/1ps
// Top of the dual-phase blink output controller.
// Assumes blink_pin is asynchronous and that software accesses registers via the
// synchronous write port and the combinational read port.
module blink_pattern_ctrl
    import blink_pkg::*;
#(
    parameter int BANK_W      = 8,
    parameter int BANKS       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int NBANKED    = BANK_W * BANKS,
    localparam int NOUT       = NBANKED + 1,
    localparam int ADDR_W     = $clog2(2 * BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blink_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BANK_W-1:0] rd_data,
    output logic [NOUT-1:0]   out_rel
);
    logic               blink_lvl;
    logic [NBANKED-1:0] pat0;
    logic [NBANKED-1:0] pat1;
    cfg_t               cfg;

    blink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (blink_pin),
        .lvl_out (blink_lvl)
    );

    pattern_regs #(.BANK_W(BANK_W), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .blink_lvl (blink_lvl),
        .rd_data   (rd_data),
        .pat0      (pat0),
        .pat1      (pat1),
        .cfg       (cfg)
    );

    phase_select #(.NBANKED(NBANKED)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat0      (pat0),
        .pat1      (pat1),
        .cfg       (cfg),
        .blink_lvl (blink_lvl),
        .out_rel   (out_rel)
    );

    // R1: the edge after a reset cycle leaves every output released
    p_reset_release_r1: assert property (@(posedge clk)
        !rst_n |=> (&out_rel));
endmodule

// File: tb/blink_pattern_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected items, monitor pops and compares.
module blink_pattern_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blink_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [16:0] out_rel;

    always #2 clk = ~clk;

    blink_pattern_ctrl uut (
        .clk(clk), .rst_n(rst_n), .blink_pin(blink_pin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .out_rel(out_rel)
    );

    // Reference state built from the requirements.
    logic [15:0] m_p0 = 16'hFFFF, m_p1 = 16'hFFFF;
    logic m_en = 0, m_flip = 0, m_o0 = 1, m_o1 = 1, m_pin = 0;

    int vectors = 0, errors = 0;
    bit done = 0;

    logic [16:0] q_out[$];
    logic [7:0]  q_rd[$];
    string       q_tag[$];
    event        item_ev;

    function automatic logic [16:0] exp_out();
        if (m_en && (m_flip ^ m_pin)) return {m_o1, m_p1};
        return {m_o0, m_p0};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_p0[7:0];
            3'd1: return m_p0[15:8];
            3'd2: return m_p1[7:0];
            3'd3: return m_p1[15:8];
            3'd4: return {m_pin, 3'b000, m_o1, m_o0, m_flip, m_en};
            default: return 8'h00;
        endcase
    endfunction

    // Driver: register write, model updated once the storing edge has passed.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: m_p0[7:0]  = d;
            3'd1: m_p0[15:8] = d;
            3'd2: m_p1[7:0]  = d;
            3'd3: m_p1[15:8] = d;
            3'd4: begin m_en = d[0]; m_flip = d[1]; m_o0 = d[2]; m_o1 = d[3]; end
            default: ;
        endcase
    endtask

    // Driver: push one expected item for the monitor.
    task automatic chk(input logic [2:0] a, input string tag);
        rd_addr = a;
        #1;
        q_out.push_back(exp_out());
        q_rd.push_back(exp_rd(a));
        q_tag.push_back(tag);
        ->item_ev;
        #0.5;
    endtask

    // Driver: change the pin, verify it is not yet visible after one edge (R8).
    task automatic set_pin(input logic v, input logic [2:0] a);
        @(negedge clk);
        blink_pin = v;
        @(negedge clk);
        chk(a, "R8 one edge");
        @(negedge clk);
        m_pin = v;
        chk(a, "R8 two edges");
    endtask

    // Monitor: pop expected items and compare against the ports.
    initial begin
        forever begin
            @(item_ev);
            while (q_tag.size() > 0) begin
                logic [16:0] eo;
                logic [7:0]  er;
                string       t;
                eo = q_out.pop_front();
                er = q_rd.pop_front();
                t  = q_tag.pop_front();
                vectors++;
                if (out_rel !== eo) begin
                    errors++;
                    $display("FAIL %s out_rel actual=%05h expected=%05h", t, out_rel, eo);
                end
                if (rd_data !== er) begin
                    errors++;
                    $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data, er);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state for every mapped register
        for (int a = 0; a < 5; a++) chk(3'(a), "R1 reset");

        // R4 and R9: phase-0 banks drive outputs 0-7 and 8-15 with stored polarity
        wr(3'd0, 8'hA5);
        chk(3'd0, "R4 R9 p0 low bank");
        wr(3'd1, 8'h3C);
        chk(3'd1, "R4 R9 p0 high bank");

        // R2 and R6: phase-1 contents readable but not driven while disabled
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'hC3);
        chk(3'd2, "R2 R6 p1 low");
        chk(3'd3, "R6 p1 high");

        // R5 and R2: flip set, out16 phase-0 low, still disabled
        wr(3'd4, 8'h0A);
        chk(3'd4, "R2 R5 flip ignored");

        // R7 and R2: pin rises while disabled; status follows, outputs do not
        set_pin(1'b1, 3'd4);
        chk(3'd0, "R2 pin ignored");

        // R3: enable, flip=1 pin=1 -> phase 0
        wr(3'd4, 8'h0B);
        chk(3'd4, "R3 flip^pin=0");
        // R3 and R8: pin falls -> phase 1
        set_pin(1'b0, 3'd4);
        chk(3'd2, "R3 R6 phase1 active");

        // R3: flip=0 pin=0 -> phase 0, out16 phase-1 low now
        wr(3'd4, 8'h05);
        chk(3'd4, "R3 R5 flip^pin=0");
        set_pin(1'b1, 3'd0);
        chk(3'd3, "R3 R5 phase1 out16 low");

        // R10: write visible straight after the storing edge while phase 1 active
        wr(3'd2, 8'h00);
        chk(3'd2, "R10 immediate");
        wr(3'd3, 8'h00);
        chk(3'd3, "R3 all low phase1");

        // R9: unmapped addresses read zero and writes change nothing
        wr(3'd5, 8'h00);
        chk(3'd5, "R9 unmapped 5");
        wr(3'd6, 8'hFF);
        chk(3'd6, "R9 unmapped 6");
        wr(3'd7, 8'h12);
        chk(3'd7, "R9 unmapped 7");
        for (int a = 0; a < 5; a++) chk(3'(a), "R9 map intact");

        // R7: writing bits 7..4 has no effect; status still tracks the pin
        wr(3'd4, 8'hF0);
        chk(3'd4, "R7 status readonly");
        set_pin(1'b0, 3'd4);
        chk(3'd1, "R2 disabled after R7 write");

        // R1: reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_p0 = 16'hFFFF; m_p1 = 16'hFFFF;
        m_en = 0; m_flip = 0; m_o0 = 1; m_o1 = 1; m_pin = 0;
        @(negedge clk);
        for (int a = 0; a < 5; a++) chk(3'(a), "R1 second reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule